// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block holds the control-flow state of one warp, a group of lanes that run in lockstep on a shared instruction stream. It keeps a stack of entries. Each entry records the next program counter, the program counter where its lanes rejoin (the reconvergence PC), and an active mask with one bit per lane. The top entry always drives the PC and active mask seen by the issue stage. On a divergent branch the lanes are split into a taken set and a not-taken set. The two sets run one after the other, and the full mask comes back once both have reached the reconvergence PC.

A transaction abort works like a loop back-edge. Lanes that failed to commit are sent back to the transaction's first instruction. Lanes that committed wait at the resume point, which is the instruction after the commit. The aborted lanes rejoin them when their retry commits. If the retry entry aborts again, it is narrowed in place and no deeper entry is pushed.

At most one event is taken per clock. Abort has priority over branch, and branch has priority over fetch. A fetch report carries the next PC of the running path. It either advances the top entry or, when that PC is the top entry's reconvergence PC, pops the entry.

Top module: `simt_reconv_stack`

## Requirements
- R1: After a synchronous reset, the stack holds one entry at PC 0 with every lane active, the level output is 1 and the overflow flag is clear.
- R2: A branch on which all active lanes agree pushes nothing and keeps the mask. The top PC becomes the taken target if all active lanes took the branch (bit i of the taken mask is lane i), or the fall-through target if none did.
- R3: A divergent branch rewrites the top entry's PC to the reconvergence PC. It then pushes a not-taken entry (fall-through PC) and above it a taken entry (target PC). The level rises by 2, and the outputs show the taken target with mask active AND taken.
- R4: A fetch whose PC differs from the top entry's reconvergence PC copies that PC into the top entry, leaving mask and level unchanged.
- R5: A fetch whose PC equals the top entry's reconvergence PC pops that entry when the level is above 1. The not-taken path appears next, and after its own pop the original mask resumes at the reconvergence PC. The bottom entry is never popped.
- R6: An abort in which some active lanes failed is handled as follows when the top entry's reconvergence PC differs from the resume PC. The top PC is set to the resume PC, and a retry entry (begin PC, reconvergence = resume PC, mask = active AND aborted) is pushed. The level rises by 1.
- R7: An abort with failed lanes on a retry entry (top reconvergence PC equals the resume PC, level above 1) pushes nothing. It sets that entry's PC to the begin PC and narrows its mask to the failed lanes.
- R8: An abort with no failed active lanes pops a retry entry. Any other entry simply moves its PC to the resume PC.
- R9: A push that does not fit (one free slot needed for abort, two for divergence) leaves the stack unchanged and sets the overflow flag. The flag stays set until reset.
- R10: When several reports arrive in the same cycle, only the highest-priority one acts: abort first, then branch, then fetch.
- R11: The active mask output is never zero, and the level stays between 1 and the stack depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch report valid |
| fetch_pc | input | PC_W | Next PC of the running path |
| br_valid | input | 1 | Branch outcome valid |
| br_taken | input | LANES | Per-lane taken bits |
| br_target | input | PC_W | Taken target PC |
| br_fallthru | input | PC_W | Not-taken PC |
| br_reconv | input | PC_W | Reconvergence PC of the branch |
| abort_valid | input | 1 | Transaction outcome valid |
| abort_lanes | input | LANES | Lanes whose transaction failed |
| tx_begin_pc | input | PC_W | First instruction of the transaction |
| tx_resume_pc | input | PC_W | Instruction after the commit |
| cur_pc | output | PC_W | PC for the issue stage |
| cur_mask | output | LANES | Active lanes for the issue stage |
| level | output | $clog2(DEPTH+1) | Number of live entries |
| overflow | output | 1 | Sticky push-overflow flag |

## Verification
Several properties are checked on every cycle. The level stays within range and the active mask is never empty. A uniform branch keeps the level and mask and jumps to the fall-through PC. A divergent branch with room adds two entries and exposes the taken lanes at the target. A divergent branch without room leaves the level alone and raises a flag that never clears. The ordering of pops and the return of the full mask at the join depend on reconvergence PCs that are not visible at the ports. The narrowing of a retry entry and the priority among simultaneous reports are hidden in the same way. These are shown only by the bench's sweeps over every taken mask and every abort mask, and by its nesting and overflow scenarios.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;

  typedef enum logic [1:0] {
    EV_IDLE,
    EV_FETCH,
    EV_BRANCH,
    EV_ABORT
  } ev_kind_t;

  // One report acts per cycle: abort, then branch, then fetch.
  function automatic ev_kind_t pick_event(input logic abort_v,
                                          input logic br_v,
                                          input logic fetch_v);
    if (abort_v)      return EV_ABORT;
    else if (br_v)    return EV_BRANCH;
    else if (fetch_v) return EV_FETCH;
    else              return EV_IDLE;
  endfunction

endpackage

// File: rtl/simt_lane_split.sv
module simt_lane_split #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] active,
  input  logic [LANES-1:0] taken,
  output logic [LANES-1:0] tk_mask,
  output logic [LANES-1:0] nt_mask,
  output logic             all_taken,
  output logic             none_taken
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign tk_mask[l] = active[l] & taken[l];
    assign nt_mask[l] = active[l] & ~taken[l];
  end

  assign none_taken = (tk_mask == '0);
  assign all_taken  = (nt_mask == '0);

endmodule

// File: rtl/simt_stack_file.sv
module simt_stack_file #(
  parameter int LANES = 4,
  parameter int DEPTH = 8,
  parameter int PC_W  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [PC_W-1:0]  rd_pc,
  output logic [PC_W-1:0]  rd_rpc,
  output logic [LANES-1:0] rd_mask,
  input  logic             wt_en,
  input  logic [PTR_W-1:0] wt_idx,
  input  logic [PC_W-1:0]  wt_pc,
  input  logic [LANES-1:0] wt_mask,
  input  logic             wa_en,
  input  logic [PTR_W-1:0] wa_idx,
  input  logic [PC_W-1:0]  wa_pc,
  input  logic [PC_W-1:0]  wa_rpc,
  input  logic [LANES-1:0] wa_mask,
  input  logic             wb_en,
  input  logic [PTR_W-1:0] wb_idx,
  input  logic [PC_W-1:0]  wb_pc,
  input  logic [PC_W-1:0]  wb_rpc,
  input  logic [LANES-1:0] wb_mask
);

  logic [PC_W-1:0]  pc_all   [DEPTH];
  logic [PC_W-1:0]  rpc_all  [DEPTH];
  logic [LANES-1:0] mask_all [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic [PC_W-1:0]  pc_r;
    logic [PC_W-1:0]  rpc_r;
    logic [LANES-1:0] mask_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        pc_r   <= '0;
        rpc_r  <= (s == 0) ? {PC_W{1'b1}} : {PC_W{1'b0}};
        mask_r <= (s == 0) ? {LANES{1'b1}} : {LANES{1'b0}};
      end else if (wt_en && wt_idx == PTR_W'(s)) begin
        pc_r   <= wt_pc;
        mask_r <= wt_mask;
      end else if (wa_en && wa_idx == PTR_W'(s)) begin
        pc_r   <= wa_pc;
        rpc_r  <= wa_rpc;
        mask_r <= wa_mask;
      end else if (wb_en && wb_idx == PTR_W'(s)) begin
        pc_r   <= wb_pc;
        rpc_r  <= wb_rpc;
        mask_r <= wb_mask;
      end
    end

    assign pc_all[s]   = pc_r;
    assign rpc_all[s]  = rpc_r;
    assign mask_all[s] = mask_r;
  end

  assign rd_pc   = pc_all[rd_idx];
  assign rd_rpc  = rpc_all[rd_idx];
  assign rd_mask = mask_all[rd_idx];

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_stack_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 8,
  parameter int PC_W  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_valid,
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_taken,
  input  logic [PC_W-1:0]  br_target,
  input  logic [PC_W-1:0]  br_fallthru,
  input  logic [PC_W-1:0]  br_reconv,
  input  logic             abort_valid,
  input  logic [LANES-1:0] abort_lanes,
  input  logic [PC_W-1:0]  tx_begin_pc,
  input  logic [PC_W-1:0]  tx_resume_pc,
  output logic [PC_W-1:0]  cur_pc,
  output logic [LANES-1:0] cur_mask,
  output logic [CNT_W-1:0] level,
  output logic             overflow
);

  logic [CNT_W-1:0] level_q, level_nx;
  logic             ovf_q, ovf_set;
  logic [PTR_W-1:0] top_idx;

  logic [PC_W-1:0]  t_pc, t_rpc;
  logic [LANES-1:0] t_mask;

  logic [LANES-1:0] tk_mask, nt_mask, failed;
  logic             all_tk, none_tk;

  logic             wt_en, wa_en, wb_en;
  logic [PC_W-1:0]  wt_pc, wa_pc, wa_rpc, wb_pc, wb_rpc;
  logic [LANES-1:0] wt_mask, wa_mask, wb_mask;
  logic [PTR_W-1:0] wa_idx, wb_idx;

  ev_kind_t ev;
  logic     can_pop, room1, room2, on_retry;

  assign top_idx = PTR_W'(level_q - 1'b1);

  simt_stack_file #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W)) u_file (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (top_idx),
    .rd_pc   (t_pc),
    .rd_rpc  (t_rpc),
    .rd_mask (t_mask),
    .wt_en   (wt_en),
    .wt_idx  (top_idx),
    .wt_pc   (wt_pc),
    .wt_mask (wt_mask),
    .wa_en   (wa_en),
    .wa_idx  (wa_idx),
    .wa_pc   (wa_pc),
    .wa_rpc  (wa_rpc),
    .wa_mask (wa_mask),
    .wb_en   (wb_en),
    .wb_idx  (wb_idx),
    .wb_pc   (wb_pc),
    .wb_rpc  (wb_rpc),
    .wb_mask (wb_mask)
  );

  simt_lane_split #(.LANES(LANES)) u_split (
    .active     (t_mask),
    .taken      (br_taken),
    .tk_mask    (tk_mask),
    .nt_mask    (nt_mask),
    .all_taken  (all_tk),
    .none_taken (none_tk)
  );

  assign failed   = t_mask & abort_lanes;
  assign ev       = pick_event(abort_valid, br_valid, fetch_valid);
  assign can_pop  = (level_q > CNT_W'(1));
  assign room1    = (level_q < CNT_W'(DEPTH));
  assign room2    = (level_q <= CNT_W'(DEPTH - 2));
  assign on_retry = can_pop && (t_rpc == tx_resume_pc);
  assign wa_idx   = PTR_W'(level_q);
  assign wb_idx   = PTR_W'(level_q + 1'b1);

  always_comb begin
    level_nx = level_q;
    ovf_set  = 1'b0;
    wt_en    = 1'b0;
    wt_pc    = t_pc;
    wt_mask  = t_mask;
    wa_en    = 1'b0;
    wa_pc    = '0;
    wa_rpc   = '0;
    wa_mask  = '0;
    wb_en    = 1'b0;
    wb_pc    = '0;
    wb_rpc   = '0;
    wb_mask  = '0;
    unique case (ev)
      EV_FETCH: begin
        if (can_pop && fetch_pc == t_rpc) begin
          level_nx = level_q - 1'b1;
        end else begin
          wt_en = 1'b1;
          wt_pc = fetch_pc;
        end
      end
      EV_BRANCH: begin
        if (none_tk) begin
          wt_en = 1'b1;
          wt_pc = br_fallthru;
        end else if (all_tk) begin
          wt_en = 1'b1;
          wt_pc = br_target;
        end else if (room2) begin
          wt_en    = 1'b1;
          wt_pc    = br_reconv;
          wa_en    = 1'b1;
          wa_pc    = br_fallthru;
          wa_rpc   = br_reconv;
          wa_mask  = nt_mask;
          wb_en    = 1'b1;
          wb_pc    = br_target;
          wb_rpc   = br_reconv;
          wb_mask  = tk_mask;
          level_nx = level_q + CNT_W'(2);
        end else begin
          ovf_set = 1'b1;
        end
      end
      EV_ABORT: begin
        if (failed == '0) begin
          if (on_retry) begin
            level_nx = level_q - 1'b1;
          end else begin
            wt_en = 1'b1;
            wt_pc = tx_resume_pc;
          end
        end else if (on_retry) begin
          wt_en   = 1'b1;
          wt_pc   = tx_begin_pc;
          wt_mask = failed;
        end else if (room1) begin
          wt_en    = 1'b1;
          wt_pc    = tx_resume_pc;
          wa_en    = 1'b1;
          wa_pc    = tx_begin_pc;
          wa_rpc   = tx_resume_pc;
          wa_mask  = failed;
          level_nx = level_q + 1'b1;
        end else begin
          ovf_set = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= CNT_W'(1);
      ovf_q   <= 1'b0;
    end else begin
      level_q <= level_nx;
      ovf_q   <= ovf_q | ovf_set;
    end
  end

  assign cur_pc   = t_pc;
  assign cur_mask = t_mask;
  assign level    = level_q;
  assign overflow = ovf_q;

endmodule

// File: rtl/simt_stack_checker.sv
module simt_stack_checker #(
  parameter int LANES = 4,
  parameter int DEPTH = 8,
  parameter int PC_W  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             br_valid,
  input logic [LANES-1:0] br_taken,
  input logic [PC_W-1:0]  br_target,
  input logic [PC_W-1:0]  br_fallthru,
  input logic             abort_valid,
  input logic [PC_W-1:0]  cur_pc,
  input logic [LANES-1:0] cur_mask,
  input logic [CNT_W-1:0] level,
  input logic             overflow
);

  localparam logic [CNT_W-1:0] ROOM2_MAX = CNT_W'(DEPTH - 2);
  localparam logic [CNT_W-1:0] LVL_MAX   = CNT_W'(DEPTH);

  logic br_only, diverge;
  assign br_only = br_valid && !abort_valid;
  assign diverge = (|(cur_mask & br_taken)) && (|(cur_mask & ~br_taken));

  p_level_bounds_r11: assert property (@(posedge clk) disable iff (rst)
    (level >= CNT_W'(1)) && (level <= LVL_MAX));

  p_mask_live_r11: assert property (@(posedge clk) disable iff (rst)
    cur_mask != '0);

  p_sticky_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  p_uniform_none_r2: assert property (@(posedge clk) disable iff (rst)
    (br_only && (cur_mask & br_taken) == '0)
    |=> ($stable(level) && $stable(cur_mask) && cur_pc == $past(br_fallthru)));

  p_diverge_push_r3: assert property (@(posedge clk) disable iff (rst)
    (br_only && diverge && level <= ROOM2_MAX)
    |=> (level == $past(level) + CNT_W'(2) && cur_pc == $past(br_target)
         && cur_mask == $past(cur_mask & br_taken)));

  p_diverge_full_r9: assert property (@(posedge clk) disable iff (rst)
    (br_only && diverge && level > ROOM2_MAX)
    |=> ($stable(level) && $stable(cur_pc) && overflow));

endmodule

bind simt_reconv_stack simt_stack_checker #(
  .LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .br_valid    (br_valid),
  .br_taken    (br_taken),
  .br_target   (br_target),
  .br_fallthru (br_fallthru),
  .abort_valid (abort_valid),
  .cur_pc      (cur_pc),
  .cur_mask    (cur_mask),
  .level       (level),
  .overflow    (overflow)
);

// File: tb/simt_reconv_stack_test.sv
`timescale 1ns/1ps
module simt_reconv_stack_test;
  localparam int LANES = 4;
  localparam int DEPTH = 8;
  localparam int PC_W  = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [3:0] FULL = 4'hF;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             fetch_valid = 1'b0;
  logic [PC_W-1:0]  fetch_pc = '0;
  logic             br_valid = 1'b0;
  logic [LANES-1:0] br_taken = '0;
  logic [PC_W-1:0]  br_target = '0, br_fallthru = '0, br_reconv = '0;
  logic             abort_valid = 1'b0;
  logic [LANES-1:0] abort_lanes = '0;
  logic [PC_W-1:0]  tx_begin_pc = '0, tx_resume_pc = '0;
  logic [PC_W-1:0]  cur_pc;
  logic [LANES-1:0] cur_mask;
  logic [CNT_W-1:0] level;
  logic             overflow;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  simt_reconv_stack #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W)) uut (.*);

  task automatic idle();
    fetch_valid = 0; br_valid = 0; abort_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst = 1;
    @(negedge clk); rst = 0;
  endtask

  task automatic tick();
    @(negedge clk); idle();
  endtask

  task automatic set_fetch(input logic [PC_W-1:0] pc);
    fetch_valid = 1; fetch_pc = pc;
  endtask

  task automatic set_branch(input logic [3:0] tm, input logic [PC_W-1:0] tg,
                            input logic [PC_W-1:0] ft, input logic [PC_W-1:0] rc);
    br_valid = 1; br_taken = tm; br_target = tg; br_fallthru = ft; br_reconv = rc;
  endtask

  task automatic set_abort(input logic [3:0] am, input logic [PC_W-1:0] bg,
                           input logic [PC_W-1:0] rs);
    abort_valid = 1; abort_lanes = am; tx_begin_pc = bg; tx_resume_pc = rs;
  endtask

  task automatic check(input string req, input logic [PC_W-1:0] e_pc,
                       input logic [3:0] e_mask, input int e_lvl, input logic e_ovf);
    n_chk++;
    if (cur_pc !== e_pc || cur_mask !== e_mask || int'(level) != e_lvl || overflow !== e_ovf) begin
      n_bad++;
      $display("FAIL %s: pc=%h mask=%b lvl=%0d ovf=%b expected pc=%h mask=%b lvl=%0d ovf=%b",
               req, cur_pc, cur_mask, level, overflow, e_pc, e_mask, e_lvl, e_ovf);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R2 R3 R4 R5: sweep every taken mask from the full mask
    for (int tm = 0; tm < 16; tm++) begin
      do_reset();
      check("R1", 16'h0, FULL, 1, 0);
      set_branch(4'(tm), 16'h20, 16'h10, 16'h40); tick();
      if (tm == 0) begin
        check("R2", 16'h10, FULL, 1, 0);
        set_fetch(16'h40); tick();
        check("R4", 16'h40, FULL, 1, 0);
      end else if (tm == 15) begin
        check("R2", 16'h20, FULL, 1, 0);
      end else begin
        check("R3", 16'h20, 4'(tm), 3, 0);
        set_fetch(16'h21); tick();
        check("R4", 16'h21, 4'(tm), 3, 0);
        set_fetch(16'h40); tick();
        check("R5", 16'h10, FULL & ~4'(tm), 2, 0);
        set_fetch(16'h40); tick();
        check("R5", 16'h40, FULL, 1, 0);
      end
    end

    // R3 R5: nested divergence
    do_reset();
    set_branch(4'b1100, 16'h20, 16'h10, 16'h40); tick();
    set_branch(4'b0100, 16'h30, 16'h28, 16'h38); tick();
    check("R3", 16'h30, 4'b0100, 5, 0);
    set_fetch(16'h38); tick();
    check("R5", 16'h28, 4'b1000, 4, 0);
    set_fetch(16'h38); tick();
    check("R5", 16'h38, 4'b1100, 3, 0);
    check("R11", cur_pc, 4'b1100, 3, 0);

    // R5: bottom entry never pops
    do_reset();
    set_fetch(16'hFFFF); tick();
    check("R5", 16'hFFFF, FULL, 1, 0);

    // R6 R7 R8: sweep every abort mask
    for (int am = 0; am < 16; am++) begin
      do_reset();
      set_abort(4'(am), 16'h08, 16'h30); tick();
      if (am == 0) begin
        check("R8", 16'h30, FULL, 1, 0);
      end else begin
        check("R6", 16'h08, 4'(am), 2, 0);
        set_abort(4'b0101, 16'h08, 16'h30); tick();
        if ((am & 5) != 0) begin
          check("R7", 16'h08, 4'(am & 5), 2, 0);
          set_abort(4'b0000, 16'h08, 16'h30); tick();
        end
        check("R8", 16'h30, FULL, 1, 0);
      end
    end

    // R9: abort push when full
    do_reset();
    for (int i = 0; i < 7; i++) begin
      set_abort(FULL, 16'h08, 16'h100 + 16'(i)); tick();
    end
    check("R6", 16'h08, FULL, 8, 0);
    set_abort(FULL, 16'h08, 16'h200); tick();
    check("R9", 16'h08, FULL, 8, 1);
    set_fetch(16'h55); tick();
    check("R9", 16'h55, FULL, 8, 1);
    do_reset();
    check("R1", 16'h0, FULL, 1, 0);

    // R9: divergence needs two slots
    for (int i = 0; i < 6; i++) begin
      set_abort(FULL, 16'h08, 16'h100 + 16'(i)); tick();
    end
    set_branch(4'b1100, 16'h20, 16'h10, 16'h40); tick();
    check("R9", 16'h08, FULL, 7, 1);

    // R10: priority among simultaneous reports
    do_reset();
    set_abort(FULL, 16'h08, 16'h30);
    set_branch(4'b1100, 16'h20, 16'h10, 16'h40);
    set_fetch(16'h77); tick();
    check("R10", 16'h08, FULL, 2, 0);
    set_branch(4'b0011, 16'h20, 16'h10, 16'h40);
    set_fetch(16'h99); tick();
    check("R10", 16'h20, 4'b0011, 4, 0);

    finish_run();
  end

endmodule